// File: doc/BRIEF.md
# DMA Address Remapping Unit

This unit sits between I/O devices and host memory on the DMA path. Each DMA request carries the 16-bit requester ID of the issuing device, a guest physical address and a read/write flag. The unit turns the address into a host physical address, or blocks the access and reports a fault. Each device is translated through its own tables. The bus number selects an entry in a root table, and that entry locates a per-bus context table. The device/function number selects the context entry. The context entry gives the device's domain tag and the base of a flat page table, which is indexed by the guest page number.

All table entries are 64-bit words, fetched through a memory read port with valid-qualified returns of any latency. Completed page translations are kept in a small fully associative translation cache, tagged by domain and guest page. A page-table fetch is skipped on a cache hit. Software clears stale cached translations with a per-domain invalidate command, which is applied before any further request is taken.

Top module: `dmar_unit`

## Requirements
- R1: The requester ID splits as bus = rid[15:8] and devfn = rid[7:0]. The first read of a request is the root entry at word address ROOT_BASE + bus. The context entry is read at (root entry bits [63:32]) + devfn.
- R2: Entry layout. Bit 0 is the present bit in every entry. In a context entry, bits [23:8] hold the domain tag and bits [63:32] the page-table base. In a page entry, bit 1 is read permission, bit 2 is write permission and bits [63:32] are the host page number. A page entry is read at (page-table base) + guest page number, where the guest page number is gaddr[31:12].
- R3: A permitted access responds with a single-cycle rsp_valid, rsp_fault = 0 and rsp_haddr = {host page number, gaddr[11:0]}. Each accepted request gives exactly one response.
- R4: The access faults if the root entry is not present (one read), if the context entry is not present (two reads), or if the page entry is not present (three reads).
- R5: A write needs the write permission and a read needs only the read permission. A missing permission gives a fault.
- R6: On every fault, flt_rid and flt_gaddr take the requester ID and guest address of the faulting request. Non-faulting responses leave them unchanged.
- R7: On a cache hit for {domain, guest page}, the request makes only the root and context reads (two reads). A miss makes the page-entry read and stores the present entry in the cache.
- R8: The cache holds 16 entries with round-robin replacement. After 17 distinct page fills, the oldest page misses and the other 16 hit.
- R9: An invalidate clears every cached entry whose domain tag equals inv_domain. Entries of other domains stay cached.
- R10: When inv_valid and req_valid are both high in the idle state, the invalidate is taken first and req_ready is low. req_ready is low while a request is in progress.
- R11: After reset: req_ready = 1, inv_ready = 1, rsp_valid = 0, mem_rd_en = 0, the fault record is zero and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | Request accepted on this cycle when valid |
| req_rid | input | 16 | Requester ID (bus, device, function) |
| req_gaddr | input | GAW | Guest physical address |
| req_write | input | 1 | 1 = DMA write, 0 = DMA read |
| inv_valid | input | 1 | Invalidate command present |
| inv_ready | output | 1 | Invalidate taken on this cycle when valid |
| inv_domain | input | DOM_W | Domain tag to invalidate |
| mem_rd_en | output | 1 | Table read strobe, one cycle |
| mem_rd_addr | output | MAW | Table word address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 64 | Returned table entry |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Access blocked |
| rsp_haddr | output | PPN_W+PG_W | Host physical address |
| flt_rid | output | 16 | Requester ID of the last fault |
| flt_gaddr | output | GAW | Guest address of the last fault |

## Verification
Cache state cannot be seen at the ports, because a hit and a miss return the same address. The bench therefore counts table reads per request: two reads on a hit, three on a miss. Eviction order is reached by filling 17 distinct pages in one domain. The bench then probes the second page before the first, so that the first probe does not disturb the replacement order. Invalidate ordering is forced by raising invalidate and request in the same cycle on an already cached page. The request must then miss.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROOT,
    ST_CTX,
    ST_LOOK,
    ST_PTE
  } walk_state_t;

  localparam int ENT_W      = 64;
  localparam int BIT_PRES   = 0;
  localparam int BIT_RD     = 1;
  localparam int BIT_WR     = 2;
  localparam int DOM_LSB    = 8;
  localparam int PTR_LSB    = 32;
endpackage

// File: rtl/dmar_iotlb.sv
module dmar_iotlb #(
  parameter int N     = 16,
  parameter int DOM_W = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DOM_W-1:0] lk_dom,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output logic             hit_rd,
  output logic             hit_wr,
  input  logic             fill_en,
  input  logic [DOM_W-1:0] fill_dom,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rd,
  input  logic             fill_wr,
  input  logic             inv_en,
  input  logic [DOM_W-1:0] inv_dom
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     vld;
  logic [DOM_W-1:0] dom_q [N];
  logic [VPN_W-1:0] vpn_q [N];
  logic [PPN_W-1:0] ppn_q [N];
  logic [N-1:0]     rd_q, wr_q;
  logic [N-1:0]     match;
  logic [IW-1:0]    ptr;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = vld[i] && (dom_q[i] == lk_dom) && (vpn_q[i] == lk_vpn);
  end

  always_comb begin
    hit     = 1'b0;
    hit_ppn = '0;
    hit_rd  = 1'b0;
    hit_wr  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_ppn = ppn_q[i];
        hit_rd  = rd_q[i];
        hit_wr  = wr_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      ptr <= '0;
    end else begin
      if (inv_en) begin
        for (int i = 0; i < N; i++)
          if (dom_q[i] == inv_dom) vld[i] <= 1'b0;
      end
      if (fill_en) begin
        vld[ptr]   <= 1'b1;
        dom_q[ptr] <= fill_dom;
        vpn_q[ptr] <= fill_vpn;
        ppn_q[ptr] <= fill_ppn;
        rd_q[ptr]  <= fill_rd;
        wr_q[ptr]  <= fill_wr;
        ptr        <= (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmar_walker.sv
module dmar_walker
  import dmar_pkg::*;
#(
  parameter int GAW   = 32,
  parameter int PG_W  = 12,
  parameter int MAW   = 32,
  parameter int PPN_W = 32,
  parameter int DOM_W = 16,
  parameter logic [MAW-1:0] ROOT_BASE = 'h1000_0000,
  localparam int VPN_W = GAW - PG_W,
  localparam int HAW   = PPN_W + PG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [15:0]      req_rid,
  input  logic [GAW-1:0]   req_gaddr,
  input  logic             req_write,
  input  logic             inv_valid,
  output logic             inv_ready,
  output logic             inv_en,
  output logic             mem_rd_en,
  output logic [MAW-1:0]   mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [ENT_W-1:0] mem_rd_data,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [HAW-1:0]   rsp_haddr,
  output logic [15:0]      flt_rid,
  output logic [GAW-1:0]   flt_gaddr,
  output logic [DOM_W-1:0] cur_dom,
  output logic [VPN_W-1:0] cur_vpn,
  input  logic             tlb_hit,
  input  logic [PPN_W-1:0] tlb_ppn,
  input  logic             tlb_rd,
  input  logic             tlb_wr,
  output logic             fill_en,
  output logic [PPN_W-1:0] fill_ppn,
  output logic             fill_rd,
  output logic             fill_wr
);
  walk_state_t    st;
  logic [15:0]    cur_rid;
  logic [GAW-1:0] cur_addr;
  logic           cur_wr;
  logic [MAW-1:0] tbase;
  logic           done, bad;
  logic [PPN_W-1:0] fin_ppn;
  logic           pres;
  logic           unused_bits;

  assign unused_bits = ^{mem_rd_data[7:3], mem_rd_data[31:DOM_LSB+DOM_W]};
  assign pres      = mem_rd_data[BIT_PRES];
  assign req_ready = (st == ST_IDLE) && !inv_valid;
  assign inv_ready = (st == ST_IDLE);
  assign inv_en    = (st == ST_IDLE) && inv_valid;
  assign cur_vpn   = cur_addr[GAW-1:PG_W];
  assign fill_ppn  = mem_rd_data[PTR_LSB +: PPN_W];
  assign fill_rd   = mem_rd_data[BIT_RD];
  assign fill_wr   = mem_rd_data[BIT_WR];

  always_comb begin
    done    = 1'b0;
    bad     = 1'b0;
    fill_en = 1'b0;
    fin_ppn = tlb_ppn;
    unique case (st)
      ST_ROOT, ST_CTX: if (mem_rd_valid && !pres) begin done = 1'b1; bad = 1'b1; end
      ST_LOOK: if (tlb_hit) begin
        done = 1'b1;
        bad  = cur_wr ? !tlb_wr : !tlb_rd;
      end
      ST_PTE: if (mem_rd_valid) begin
        done = 1'b1;
        if (!pres) bad = 1'b1;
        else begin
          fill_en = 1'b1;
          fin_ppn = fill_ppn;
          bad     = cur_wr ? !fill_wr : !fill_rd;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_haddr   <= '0;
      flt_rid     <= '0;
      flt_gaddr   <= '0;
      cur_rid     <= '0;
      cur_addr    <= '0;
      cur_wr      <= 1'b0;
      cur_dom     <= '0;
      tbase       <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      rsp_valid <= 1'b0;
      if (done) begin
        st        <= ST_IDLE;
        rsp_valid <= 1'b1;
        rsp_fault <= bad;
        rsp_haddr <= bad ? '0 : {fin_ppn, cur_addr[PG_W-1:0]};
        if (bad) begin
          flt_rid   <= cur_rid;
          flt_gaddr <= cur_addr;
        end
      end else begin
        unique case (st)
          ST_IDLE: if (req_ready && req_valid) begin
            cur_rid     <= req_rid;
            cur_addr    <= req_gaddr;
            cur_wr      <= req_write;
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= ROOT_BASE + MAW'(req_rid[15:8]);
            st          <= ST_ROOT;
          end
          ST_ROOT: if (mem_rd_valid) begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= mem_rd_data[PTR_LSB +: MAW] + MAW'(cur_rid[7:0]);
            st          <= ST_CTX;
          end
          ST_CTX: if (mem_rd_valid) begin
            cur_dom <= mem_rd_data[DOM_LSB +: DOM_W];
            tbase   <= mem_rd_data[PTR_LSB +: MAW];
            st      <= ST_LOOK;
          end
          ST_LOOK: begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= tbase + MAW'(cur_vpn);
            st          <= ST_PTE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmar_unit.sv
module dmar_unit #(
  parameter int GAW    = 32,
  parameter int PG_W   = 12,
  parameter int MAW    = 32,
  parameter int PPN_W  = 32,
  parameter int DOM_W  = 16,
  parameter int TLB_N  = 16,
  parameter logic [MAW-1:0] ROOT_BASE = 'h1000_0000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [15:0]           req_rid,
  input  logic [GAW-1:0]        req_gaddr,
  input  logic                  req_write,
  input  logic                  inv_valid,
  output logic                  inv_ready,
  input  logic [DOM_W-1:0]      inv_domain,
  output logic                  mem_rd_en,
  output logic [MAW-1:0]        mem_rd_addr,
  input  logic                  mem_rd_valid,
  input  logic [63:0]           mem_rd_data,
  output logic                  rsp_valid,
  output logic                  rsp_fault,
  output logic [PPN_W+PG_W-1:0] rsp_haddr,
  output logic [15:0]           flt_rid,
  output logic [GAW-1:0]        flt_gaddr
);
  localparam int VPN_W = GAW - PG_W;

  logic             inv_en, tlb_hit, tlb_rd, tlb_wr, fill_en, fill_rd, fill_wr;
  logic [DOM_W-1:0] cur_dom;
  logic [VPN_W-1:0] cur_vpn;
  logic [PPN_W-1:0] tlb_ppn, fill_ppn;

  dmar_walker #(
    .GAW(GAW), .PG_W(PG_W), .MAW(MAW), .PPN_W(PPN_W), .DOM_W(DOM_W), .ROOT_BASE(ROOT_BASE)
  ) u_walk (
    .clk, .rst, .req_valid, .req_ready, .req_rid, .req_gaddr, .req_write,
    .inv_valid, .inv_ready, .inv_en,
    .mem_rd_en, .mem_rd_addr, .mem_rd_valid, .mem_rd_data,
    .rsp_valid, .rsp_fault, .rsp_haddr, .flt_rid, .flt_gaddr,
    .cur_dom, .cur_vpn, .tlb_hit, .tlb_ppn, .tlb_rd, .tlb_wr,
    .fill_en, .fill_ppn, .fill_rd, .fill_wr
  );

  dmar_iotlb #(
    .N(TLB_N), .DOM_W(DOM_W), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_tlb (
    .clk, .rst,
    .lk_dom(cur_dom), .lk_vpn(cur_vpn),
    .hit(tlb_hit), .hit_ppn(tlb_ppn), .hit_rd(tlb_rd), .hit_wr(tlb_wr),
    .fill_en, .fill_dom(cur_dom), .fill_vpn(cur_vpn), .fill_ppn,
    .fill_rd, .fill_wr,
    .inv_en, .inv_dom(inv_domain)
  );
endmodule

// File: rtl/dmar_unit_chk.sv
module dmar_unit_chk #(
  parameter int GAW   = 32,
  parameter int PG_W  = 12,
  parameter int PPN_W = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [15:0]           req_rid,
  input logic [GAW-1:0]        req_gaddr,
  input logic                  inv_valid,
  input logic                  mem_rd_en,
  input logic                  rsp_valid,
  input logic                  rsp_fault,
  input logic [PPN_W+PG_W-1:0] rsp_haddr,
  input logic [15:0]           flt_rid,
  input logic [GAW-1:0]        flt_gaddr
);
  logic [15:0]    seen_rid;
  logic [GAW-1:0] seen_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_rid  <= '0;
      seen_addr <= '0;
    end else if (req_valid && req_ready) begin
      seen_rid  <= req_rid;
      seen_addr <= req_gaddr;
    end
  end

  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_offset_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> rsp_haddr[PG_W-1:0] == seen_addr[PG_W-1:0]);

  p_flt_record_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (flt_rid == seen_rid && flt_gaddr == seen_addr));

  p_flt_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> ($stable(flt_rid) && $stable(flt_gaddr)));

  p_inv_first_r10: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> !req_ready);

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_read_while_busy_r7: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);
endmodule

bind dmar_unit dmar_unit_chk #(.GAW(GAW), .PG_W(PG_W), .PPN_W(PPN_W)) u_chk (
  .clk, .rst, .req_valid, .req_ready, .req_rid, .req_gaddr, .inv_valid,
  .mem_rd_en, .rsp_valid, .rsp_fault, .rsp_haddr, .flt_rid, .flt_gaddr
);

// File: tb/dmar_unit_tb.sv
`timescale 1ns/1ps
module dmar_unit_tb;
  localparam logic [31:0] HPN_MIX = 32'h0A5A_5000;

  logic        clk = 0, rst = 1;
  logic        req_valid = 0, req_write = 0, inv_valid = 0;
  logic [15:0] req_rid = 0;
  logic [31:0] req_gaddr = 0;
  logic [15:0] inv_domain = 0;
  logic        req_ready, inv_ready, mem_rd_en, rsp_valid, rsp_fault;
  logic [31:0] mem_rd_addr, flt_gaddr;
  logic        mem_rd_valid = 0;
  logic [63:0] mem_rd_data = 0;
  logic [43:0] rsp_haddr;
  logic [15:0] flt_rid;
  int total = 0, bad = 0, nreads = 0;

  always #10 clk = ~clk;

  dmar_unit u_dut (
    .clk, .rst, .req_valid, .req_ready, .req_rid, .req_gaddr, .req_write,
    .inv_valid, .inv_ready, .inv_domain, .mem_rd_en, .mem_rd_addr,
    .mem_rd_valid, .mem_rd_data, .rsp_valid, .rsp_fault, .rsp_haddr,
    .flt_rid, .flt_gaddr
  );

  function automatic logic [63:0] mem_fn(input logic [31:0] a);
    logic [63:0] e;
    logic [31:0] off;
    logic [7:0]  b, df;
    logic [19:0] g;
    e = '0;
    if (a < 32'h2000_0000) begin
      b = a[7:0];
      if (b != 8'hEE) begin e[0] = 1; e[63:32] = 32'h2000_0000 + {16'h0, b, 8'h0}; end
    end else if (a < 32'h4000_0000) begin
      off = a - 32'h2000_0000; b = off[15:8]; df = off[7:0];
      if (df != 8'h07) begin
        e[0] = 1; e[23:8] = {8'h0, b}; e[63:32] = 32'h4000_0000 + {4'h0, b, 20'h0};
      end
    end else begin
      off = a - 32'h4000_0000; b = off[27:20]; g = off[19:0];
      if (g[3:0] != 4'hF) begin
        e[0] = 1; e[1] = (g[5:4] != 2'b11); e[2] = !g[4];
        e[63:32] = {4'h0, b, g} ^ HPN_MIX;
      end
    end
    return e;
  endfunction

  function automatic logic exp_fault(input logic [15:0] rid, input logic [31:0] ga, input logic wr);
    logic [19:0] g;
    g = ga[31:12];
    return rid[15:8] == 8'hEE || rid[7:0] == 8'h07 || g[3:0] == 4'hF ||
           (wr ? g[4] : (g[5:4] == 2'b11));
  endfunction

  function automatic logic [43:0] exp_haddr(input logic [15:0] rid, input logic [31:0] ga);
    return {({4'h0, rid[15:8], ga[31:12]} ^ HPN_MIX), ga[11:0]};
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_rd_en) begin
      mem_rd_valid <= 1'b1;
      mem_rd_data  <= mem_fn(mem_rd_addr);
      nreads       <= nreads + 1;
    end
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  logic        r_fault;
  logic [43:0] r_haddr;
  int          r_reads;

  task automatic do_req(input logic [15:0] rid, input logic [31:0] ga, input logic wr);
    int n0;
    @(negedge clk);
    req_valid = 1; req_rid = rid; req_gaddr = ga; req_write = wr;
    n0 = nreads;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    r_fault = rsp_fault; r_haddr = rsp_haddr; r_reads = nreads - n0;
    @(negedge clk);
    check(!rsp_valid, "R3 pulse", 64'(rsp_valid), 0);
  endtask

  task automatic req_check(input logic [15:0] rid, input logic [31:0] ga, input logic wr, input string tag);
    logic ef;
    do_req(rid, ga, wr);
    ef = exp_fault(rid, ga, wr);
    check(r_fault == ef, {tag, " fault"}, 64'(r_fault), 64'(ef));
    if (!ef) check(r_haddr == exp_haddr(rid, ga), {tag, " haddr"}, 64'(r_haddr), 64'(exp_haddr(rid, ga)));
  endtask

  task automatic do_inv(input logic [15:0] dom);
    @(negedge clk);
    inv_valid = 1; inv_domain = dom;
    while (!inv_ready) @(negedge clk);
    @(negedge clk);
    inv_valid = 0;
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s;
    s = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check(req_ready && inv_ready && !rsp_valid && !mem_rd_en, "R11 reset",
          {60'h0, req_ready, inv_ready, rsp_valid, mem_rd_en}, 64'hC);
    check(flt_rid == 0 && flt_gaddr == 0, "R11 fault record", {16'h0, flt_rid, flt_gaddr}, 0);

    // R1 R2 R3 R7: first access misses, second hits
    req_check(16'h1234, 32'h0001_0123, 0, "R3 first");
    check(r_reads == 3, "R7 miss reads", 64'(r_reads), 3);
    req_check(16'h1234, 32'h0001_0ABC, 1, "R1 second");
    check(r_reads == 2, "R7 hit reads", 64'(r_reads), 2);

    // R5 permissions: page 0x00013 readable, not writable
    req_check(16'h1235, 32'h0001_3004, 0, "R5 read ok");
    req_check(16'h1235, 32'h0001_3008, 1, "R5 write blocked");
    check(r_fault, "R5 write fault", 64'(r_fault), 1);
    check(flt_rid == 16'h1235 && flt_gaddr == 32'h0001_3008, "R6 record",
          {16'h0, flt_rid, flt_gaddr}, {32'h1235, 32'h0001_3008});
    req_check(16'h1235, 32'h0003_0000, 0, "R5 read blocked");

    // R4 not present at each level
    req_check(16'hEE01, 32'h0000_1000, 0, "R4 root");
    check(r_fault && r_reads == 1, "R4 root reads", 64'(r_reads), 1);
    req_check(16'h2207, 32'h0000_1000, 0, "R4 ctx");
    check(r_fault && r_reads == 2, "R4 ctx reads", 64'(r_reads), 2);
    req_check(16'h2201, 32'h0000_F000, 0, "R4 pte");
    check(r_fault && r_reads == 3, "R4 pte reads", 64'(r_reads), 3);
    check(flt_rid == 16'h2201 && flt_gaddr == 32'h0000_F000, "R6 pte record",
          {16'h0, flt_rid, flt_gaddr}, {32'h2201, 32'h0000_F000});
    req_check(16'h2201, 32'h0000_1000, 0, "R6 hold");
    check(flt_rid == 16'h2201 && flt_gaddr == 32'h0000_F000, "R6 hold unchanged",
          {16'h0, flt_rid, flt_gaddr}, {32'h2201, 32'h0000_F000});

    // R8 round robin: 17 fills, oldest evicted
    for (int i = 0; i < 17; i++) req_check(16'h2100, {20'(32'h100 + i * 64), 12'h0}, 0, "R8 fill");
    req_check(16'h2100, {20'(32'h100 + 64), 12'h0}, 0, "R8 keep");
    check(r_reads == 2, "R8 second kept", 64'(r_reads), 2);
    req_check(16'h2100, {20'h00100, 12'h0}, 0, "R8 evict");
    check(r_reads == 3, "R8 oldest evicted", 64'(r_reads), 3);

    // R9 per-domain invalidate
    req_check(16'h3000, 32'h0000_2000, 0, "R9 fill a");
    req_check(16'h3100, 32'h0000_2000, 0, "R9 fill b");
    do_inv(16'h0030);
    req_check(16'h3000, 32'h0000_2000, 0, "R9 a");
    check(r_reads == 3, "R9 cleared domain", 64'(r_reads), 3);
    req_check(16'h3100, 32'h0000_2000, 0, "R9 b");
    check(r_reads == 2, "R9 other domain kept", 64'(r_reads), 2);

    // R10 invalidate and request in the same cycle
    req_check(16'h4000, 32'h0000_5000, 0, "R10 fill");
    @(negedge clk);
    inv_valid = 1; inv_domain = 16'h0040;
    req_valid = 1; req_rid = 16'h4000; req_gaddr = 32'h0000_5000; req_write = 0;
    #1 check(!req_ready, "R10 ready low", 64'(req_ready), 0);
    @(negedge clk);
    inv_valid = 0;
    req_valid = 0;
    req_check(16'h4000, 32'h0000_5000, 0, "R10 after");
    check(r_reads == 3, "R10 invalidate first", 64'(r_reads), 3);

    // Random mix
    for (int k = 0; k < 300; k++) begin
      logic [7:0]  b, df;
      logic [31:0] ga;
      b  = ($urandom % 9 == 0) ? 8'hEE : 8'(8'h50 + $urandom % 4);
      df = ($urandom % 11 == 0) ? 8'h07 : 8'($urandom % 4);
      ga = {20'($urandom % 48), 12'($urandom)};
      if ($urandom % 25 == 0) do_inv(16'(8'h50 + $urandom % 4));
      req_check({b, df}, ga, 1'($urandom), "R3 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule